// File: doc/BRIEF.md
# Clock Startup and Bus-Clock Sequencer

This block sits between the clock sources and the rest of the chip. It takes two single-cycle tick enables: one from the crystal oscillator and one from the PLL. A select input picks one of them as the base clock. The block divides the chosen ticks by four and produces the bus-phase enables.

After a power-on or low-voltage request, the bus enables are held silent while a counter runs for a fixed number of crystal ticks. The active-low external reset pin is driven low for that whole period. The counter sees only crystal ticks, so the timeout does not depend on the PLL having locked.

Everything runs in one synchronous clock domain, and every clock is modelled as an enable pulse. A state machine has three states:

- **HOLD**: the reset pin is low and the timeout counter runs.
- **ARMED**: the timeout has finished and the divider runs, but the first bus edge has not yet come.
- **RUN**: normal operation.

There are four transitions:

- HOLD→ARMED on the final crystal tick of the count, with no request present.
- ARMED→RUN on the first bus rise enable.
- ARMED→HOLD on any request.
- RUN→HOLD on any request.

A request while in HOLD keeps the state in HOLD and clears the count.

Top module: `clkseq_top`

## Requirements
- R1: The selected tick is `pll_tick` when the latched select is 1 and `xtal_tick` when it is 0. Ticks of the unselected source never advance the divider.
- R2: Outside HOLD, a two-stage divider counts selected ticks through phases 0,1,2,3 and then wraps. `bus_fall_en` pulses on the selected tick that arrives in phase 1. `bus_rise_en` pulses on the selected tick that arrives in phase 3, which is the end of every four ticks. Both are combinational in that cycle.
- R3: While in HOLD, `bus_rise_en` and `bus_fall_en` stay 0 and the divider is held at phase 0.
- R4: With no request, HOLD lasts exactly HOLD_CYCLES (default 4096) crystal ticks. `rst_pin_n` reads 0 throughout HOLD and becomes 1 in the cycle after the final tick.
- R5: PLL ticks never advance the startup count.
- R6: A request (`por_req` or `lvi_req` high in a cycle) from any state enters HOLD with the count at zero. `rst_pin_n` is 0 from the next cycle on. A request has priority over a crystal tick in the same cycle.
- R7: A change of `src_sel` is latched only while in HOLD or on the cycle of a bus rise enable (phase wrap). At all other times the latched select keeps its value.
- R8: `clk_running` rises in the cycle after the first `bus_rise_en` that follows the release, and falls with the next request.
- R9: After `rst_n` is released, the block is in HOLD with a count of zero. `rst_pin_n`, `clk_running` and both bus enables are 0, and the latched select is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock for all logic |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| xtal_tick | input | 1 | Crystal clock enable, one cycle per crystal tick |
| pll_tick | input | 1 | PLL clock enable, one cycle per PLL tick |
| src_sel | input | 1 | Base source select: 1 selects PLL, 0 selects crystal |
| por_req | input | 1 | Power-on reset request |
| lvi_req | input | 1 | Low-voltage reset request |
| bus_rise_en | output | 1 | Bus phase enable at the end of every fourth selected tick |
| bus_fall_en | output | 1 | Bus phase enable at the mid point of the four-tick bus period |
| rst_pin_n | output | 1 | External reset pin state, low during the startup hold |
| clk_running | output | 1 | High from the cycle after the first bus rise after release |

## Verification
The assertions assume that each tick input is a clean one-cycle enable sampled on `clk`. They also assume that the requests and `src_sel` are already synchronous to `clk`, so that a request, a tick and a select change may all fall in the same cycle without any ordering between them.

The stimulus is driven away from the active edge and draws from a fixed seed. It randomizes the tick density of each source, flips the select at arbitrary phases and issues rare requests, including requests during HOLD and ARMED. Directed cases pin down the exact release cycle, a restart in the middle of the count, a select change in the middle of a phase, and a crystal source that goes silent.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/clkseq_src_mux.sv
module clkseq_src_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic pll_tick,
    input  logic src_sel,
    input  logic hold,
    input  logic wrap,
    output logic sel_q,
    output logic src_tick
);
    // The select is latched only at a phase boundary (wrap) or while the bus is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (hold || wrap) begin
            sel_q <= src_sel;
        end
    end

    always_comb begin
        src_tick = sel_q ? pll_tick : xtal_tick;
    end

    // R7: the latched select keeps its value inside a bus phase
    a_r7_sel_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !wrap) |=> $stable(sel_q));
endmodule

// File: rtl/clkseq_div.sv
module clkseq_div #(
    parameter int DIV_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic rise_en,
    output logic fall_en,
    output logic [DIV_STAGES-1:0] phase
);
    logic [DIV_STAGES:0] carry;

    assign carry[0] = tick;

    // Each stage is a divide-by-two that toggles when every lower stage carries.
    for (genvar i = 0; i < DIV_STAGES; i++) begin : g_stage
        assign carry[i+1] = carry[i] & phase[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                phase[i] <= 1'b0;
            end else if (!run) begin
                phase[i] <= 1'b0;
            end else if (carry[i]) begin
                phase[i] <= ~phase[i];
            end
        end
    end

    always_comb begin
        rise_en = run & carry[DIV_STAGES];
        fall_en = run & carry[DIV_STAGES-1] & ~phase[DIV_STAGES-1];
    end

    // R2: each selected tick while running advances the phase by one
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (!$past(run) || phase == $past(phase) + 1'b1));

    // R2: a tick that does not arrive leaves the phase unchanged
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(phase));

    // R3: no bus enable leaves the divider while it is idle
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!rise_en && !fall_en));

    // R2: the rise and fall enables never fire together
    a_r2_enables_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_en, fall_en}));
endmodule

// File: rtl/clkseq_startup_fsm.sv
module clkseq_startup_fsm
    import clkseq_pkg::*;
#(
    parameter int HOLD_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic req,
    input  logic bus_rise,
    output logic hold,
    output logic rst_pin_n,
    output logic running
);
    localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    seq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_HOLD: begin
                if (req) begin
                    cnt_d = '0;
                end else if (xtal_tick) begin
                    if (cnt_q == LAST) begin
                        state_d = SEQ_ARMED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SEQ_ARMED: begin
                cnt_d = '0;
                if (req) begin
                    state_d = SEQ_HOLD;
                end else if (bus_rise) begin
                    state_d = SEQ_RUN;
                end
            end
            SEQ_RUN: begin
                cnt_d = '0;
                if (req) begin
                    state_d = SEQ_HOLD;
                end
            end
            default: begin
                state_d = SEQ_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        hold      = (state_q == SEQ_HOLD);
        rst_pin_n = (state_q != SEQ_HOLD);
        running   = (state_q == SEQ_RUN);
    end

    // R6: a request always lands in HOLD with a cleared count
    a_r6_req_restart: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!rst_pin_n && cnt_q == '0));

    // R5: without a crystal tick the startup count does not move
    a_r5_count_needs_xtal: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !req && !xtal_tick) |=> (hold && $stable(cnt_q)));

    // R4: the final crystal tick of the count releases the pin
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !req && xtal_tick && cnt_q == LAST) |=> rst_pin_n);

    // R4: a crystal tick before the last one keeps the pin low
    a_r4_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !req && cnt_q != LAST) |=> !rst_pin_n);

    // R8: running status only begins right after a bus rise
    a_r8_status_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(bus_rise));
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top #(
    parameter int HOLD_CYCLES = 4096,
    parameter int DIV_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal_tick,
    input  logic pll_tick,
    input  logic src_sel,
    input  logic por_req,
    input  logic lvi_req,
    output logic bus_rise_en,
    output logic bus_fall_en,
    output logic rst_pin_n,
    output logic clk_running
);
    logic req;
    logic hold;
    logic sel_q;
    logic src_tick;
    logic [DIV_STAGES-1:0] phase;

    assign req = por_req | lvi_req;

    clkseq_startup_fsm #(
        .HOLD_CYCLES (HOLD_CYCLES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .req       (req),
        .bus_rise  (bus_rise_en),
        .hold      (hold),
        .rst_pin_n (rst_pin_n),
        .running   (clk_running)
    );

    clkseq_src_mux u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .pll_tick  (pll_tick),
        .src_sel   (src_sel),
        .hold      (hold),
        .wrap      (bus_rise_en),
        .sel_q     (sel_q),
        .src_tick  (src_tick)
    );

    clkseq_div #(
        .DIV_STAGES (DIV_STAGES)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!hold),
        .tick    (src_tick),
        .rise_en (bus_rise_en),
        .fall_en (bus_fall_en),
        .phase   (phase)
    );

    // R1: a bus enable can only occur on a tick of the latched source
    a_r1_source_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rise_en || bus_fall_en) |-> (sel_q ? pll_tick : xtal_tick));

    // R3: the pin stays low and the bus stays quiet together
    a_r3_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_n |-> (!bus_rise_en && !bus_fall_en && !clk_running));
endmodule

// File: tb/clkseq_top_tb.sv
module clkseq_top_tb;
    localparam int HOLD = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xtal_tick = 1'b0, pll_tick = 1'b0, src_sel = 1'b0, por_req = 1'b0, lvi_req = 1'b0;
    logic bus_rise_en, bus_fall_en, rst_pin_n, clk_running;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state
    int m_st = 0;
    int m_cnt = 0;
    int m_div = 0;
    bit m_sel = 1'b0;

    // Outputs as seen in the most recent cycle
    bit o_rise, o_fall, o_pin, o_run;

    always #4 clk = ~clk;

    clkseq_top #(.HOLD_CYCLES(HOLD), .DIV_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .pll_tick(pll_tick),
        .src_sel(src_sel), .por_req(por_req), .lvi_req(lvi_req),
        .bus_rise_en(bus_rise_en), .bus_fall_en(bus_fall_en),
        .rst_pin_n(rst_pin_n), .clk_running(clk_running)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_tick(input bit x, input bit p);
        return m_sel ? p : x;
    endfunction

    // One cycle: drive, compare against the model, then advance the model
    task automatic cyc(input bit x, input bit p, input bit s, input bit por, input bit lvi);
        bit hold_m, tk, wrap, fall;
        @(negedge clk);
        xtal_tick = x; pll_tick = p; src_sel = s; por_req = por; lvi_req = lvi;
        #1;
        hold_m = (m_st == 0);
        tk = exp_tick(x, p);
        wrap = !hold_m && tk && (m_div == 3);
        fall = !hold_m && tk && (m_div == 1);
        o_rise = bus_rise_en; o_fall = bus_fall_en; o_pin = rst_pin_n; o_run = clk_running;
        check("R2 bus_rise_en", int'(bus_rise_en), int'(wrap));
        check("R2 bus_fall_en", int'(bus_fall_en), int'(fall));
        check("R4 rst_pin_n", int'(rst_pin_n), int'(!hold_m));
        check("R8 clk_running", int'(clk_running), int'(m_st == 2));
        @(posedge clk);
        if (hold_m || wrap) m_sel = s;
        if (hold_m) m_div = 0;
        else if (tk) m_div = (m_div + 1) % 4;
        if (por || lvi) begin
            m_st = 0; m_cnt = 0;
        end else begin
            case (m_st)
                0: if (x) begin
                       if (m_cnt == HOLD - 1) begin m_st = 1; m_cnt = 0; end
                       else m_cnt = m_cnt + 1;
                   end
                1: if (wrap) m_st = 2;
                default: ;
            endcase
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        int cnt;
        void'($urandom(32'd20240611));
        #20;
        // R9: reset state
        check("R9 rst_pin_n", int'(rst_pin_n), 0);
        check("R9 clk_running", int'(clk_running), 0);
        check("R9 bus_rise_en", int'(bus_rise_en), 0);
        @(negedge clk); rst_n = 1'b1;

        // R5: PLL ticks alone never end the hold
        for (int i = 0; i < 5000; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R5 pin low after PLL-only ticks", int'(o_pin), 0);

        // R4: exact hold length counted in crystal ticks
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        cnt = 0;
        for (int i = 0; i < 10000; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
            if (o_pin) break;
            cnt++;
            // R3: quiet bus while held
            if (o_rise || o_fall) check("R3 enable during hold", 1, 0);
        end
        check("R4 hold length", cnt, HOLD);

        // R8: four cycles with pin high before running rises
        cnt = 1;
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            if (o_run) break;
            cnt++;
        end
        check("R8 cycles to running", cnt, 4);

        // R7: switch to silent PLL in mid-phase; only the pending wrap completes
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
            if (o_rise) cnt++;
        end
        check("R7 rises after mid-phase switch", cnt, 1);

        // R1: PLL ticks now drive the divider, crystal ignored
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
            if (o_rise) cnt++;
        end
        check("R1 PLL rises in 40 ticks", cnt, 10);

        // R6: low-voltage request in run drops the pin next cycle
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R6 pin low after request", int'(o_pin), 0);
        check("R6 running cleared", int'(o_run), 0);

        // R6: restart mid-count gives a full hold again
        for (int i = 0; i < 2000; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        cnt = 0;
        for (int i = 0; i < 10000; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            if (o_pin) break;
            cnt++;
        end
        check("R6 hold length after restart", cnt, HOLD);

        // Random traffic checked cycle by cycle against the model
        begin
            bit s = 1'b0;
            for (int i = 0; i < 60000; i++) begin
                bit x, p, por, lvi;
                x = ($urandom % 2) == 0;
                p = ($urandom % 4) != 0;
                if (($urandom % 500) == 0) s = ~s;
                por = ($urandom % 5000) == 0;
                lvi = ($urandom % 5000) == 0;
                cyc(x, p, s, por, lvi);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule